// File: doc/BRIEF.md
# Wired Interrupt Command Executor

This block keeps the configuration and live state of a small set of shared wired interrupts and changes it in response to 64-bit command words. A command arrives on a valid/ready pair. Its opcode picks one operation: enable, disable, set priority, set target affinity, write the pending bit, select edge or level handling, acknowledge, end of interrupt, or read back. Every word carries an interrupt type and an interrupt ID. Only the wired shared type touches the table.

A readback command copies the addressed entry into a set of registered status outputs and raises a one-cycle done strobe. A fault flag marks a readback whose type or ID is invalid. A barrier request stops new commands from being accepted. The barrier is acknowledged only after the command already accepted has been applied. Software can therefore rely on a disable having landed before it continues.

Top module: `irq_cmd_engine`

## Requirements
- R1: After reset every entry is disabled, not pending, not active, edge mode, with priority 0, routing bit 0 and affinity 0. rb_done and every status output read 0.
- R2: Word fields are: opcode in bits 63:60, type in bits 31:29, ID in bits 23:0. A command whose type is not 3 leaves the table unchanged.
- R3: A command whose ID is at or above NUM_IRQ leaves every entry unchanged, including the entry whose index equals the ID's low bits.
- R4: Opcode 0 sets the enable bit of the addressed entry. Opcode 1 clears it.
- R5: Opcode 2 loads the entry priority from bits 39:35.
- R6: Opcode 3 loads the 16-bit affinity from bits 47:32 and the routing bit from bit 28.
- R7: Opcode 4 writes bit 32 into the pending bit, so it both sets and clears pending. Opcode 7 writes bit 32 into the mode bit, where 1 means level.
- R8: Opcode 8 on an entry that is both enabled and pending sets active and clears pending; on any other entry it changes nothing. Opcode 5 clears active.
- R9: Opcode 6 pulses rb_done for one cycle, two clock edges after acceptance, and loads the status outputs with the entry. When the type is not 3 or the ID is out of range, rb_fault is 1 and all other status fields are 0. The status outputs hold their value until the next readback, and rb_done stays low for other opcodes.
- R10: Opcodes 9 to 15 change nothing.
- R11: While bar_req is high, cmd_ready is low. bar_ack rises one edge after a cycle with bar_req high and no accepted command waiting to be applied, so an accepted disable is applied before the acknowledge.
- R12: cmd_ready is low during reset and high from the first edge after reset is released, when bar_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_word | input | 64 | Packed command word |
| bar_req | input | 1 | Barrier request |
| bar_ack | output | 1 | Barrier acknowledge, all accepted commands applied |
| rb_done | output | 1 | One-cycle strobe, status outputs refreshed |
| rb_fault | output | 1 | Last readback was invalid |
| rb_pend | output | 1 | Pending bit of the read entry |
| rb_act | output | 1 | Active bit of the read entry |
| rb_en | output | 1 | Enable bit of the read entry |
| rb_lvl | output | 1 | Mode bit of the read entry, 1 = level |
| rb_prio | output | 5 | Priority of the read entry |
| rb_route | output | 1 | Routing-mode bit of the read entry |
| rb_aff | output | 16 | Target affinity ID of the read entry |

## Verification
The bench uses the default NUM_IRQ of 16. This keeps the whole table small enough to sweep after reset, and random IDs drawn from 0 to 19 also land above the table. IDs 16 to 19 share their low four bits with entries 0 to 3. This exposes any decoder that truncates the ID instead of range-checking it. About one fifth of the random words carry a type other than 3, and opcodes up to 15 appear. These cover the ignored and fault paths next to the normal table operations.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

  localparam int CMD_W  = 64;
  localparam int ID_W   = 24;
  localparam int PRIO_W = 5;
  localparam int AFF_W  = 16;

  localparam int OP_LSB    = 60;
  localparam int TYPE_LSB  = 29;
  localparam int ROUTE_BIT = 28;
  localparam int FLAG_BIT  = 32;
  localparam int PRIO_LSB  = 35;
  localparam int AFF_LSB   = 32;

  localparam logic [2:0] TYPE_WIRED = 3'd3;

  typedef enum logic [3:0] {
    OP_EN   = 4'd0,
    OP_DIS  = 4'd1,
    OP_PRIO = 4'd2,
    OP_AFF  = 4'd3,
    OP_PEND = 4'd4,
    OP_EOI  = 4'd5,
    OP_RDBK = 4'd6,
    OP_MODE = 4'd7,
    OP_ACK  = 4'd8
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              type_ok;
    logic              route;
    logic              flag;
    logic [PRIO_W-1:0] prio;
    logic [AFF_W-1:0]  aff;
    logic [ID_W-1:0]   id;
  } cmd_t;

  typedef struct packed {
    logic              pend;
    logic              act;
    logic              en;
    logic              lvl;
    logic [PRIO_W-1:0] prio;
    logic              route;
    logic [AFF_W-1:0]  aff;
  } entry_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_t             cmd
);

  logic unused_bits;
  assign unused_bits = ^{word[59:48], word[27:24]};

  always_comb begin
    cmd.op      = op_e'(word[OP_LSB +: 4]);
    cmd.type_ok = (word[TYPE_LSB +: 3] == TYPE_WIRED);
    cmd.route   = word[ROUTE_BIT];
    cmd.flag    = word[FLAG_BIT];
    cmd.prio    = word[PRIO_LSB +: PRIO_W];
    cmd.aff     = word[AFF_LSB +: AFF_W];
    cmd.id      = word[ID_W-1:0];
  end

endmodule

// File: rtl/irq_state_table.sv
module irq_state_table
  import irq_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   upd_vld,
  input  cmd_t   upd,
  output logic   sel_ok,
  output entry_t sel_ent
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  entry_t           tbl [NUM_IRQ];
  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (upd.id < ID_W'(NUM_IRQ));
  assign idx      = upd.id[IDX_W-1:0];
  assign sel_ok   = in_range && upd.type_ok;
  assign sel_ent  = sel_ok ? tbl[idx] : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ent
    logic hit;
    assign hit = upd_vld && sel_ok && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[g] <= '0;
      end else if (hit) begin
        case (upd.op)
          OP_EN:   tbl[g].en   <= 1'b1;
          OP_DIS:  tbl[g].en   <= 1'b0;
          OP_PRIO: tbl[g].prio <= upd.prio;
          OP_AFF: begin
            tbl[g].aff   <= upd.aff;
            tbl[g].route <= upd.route;
          end
          OP_PEND: tbl[g].pend <= upd.flag;
          OP_MODE: tbl[g].lvl  <= upd.flag;
          OP_EOI:  tbl[g].act  <= 1'b0;
          OP_ACK: begin
            if (tbl[g].en && tbl[g].pend) begin
              tbl[g].act  <= 1'b1;
              tbl[g].pend <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ld,
  input  logic   ok,
  input  entry_t ent,
  output logic   done,
  output logic   fault,
  output entry_t st
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      fault <= 1'b0;
      st    <= '0;
    end else begin
      done <= ld;
      if (ld) begin
        fault <= !ok;
        st    <= ok ? ent : '0;
      end
    end
  end

endmodule

// File: rtl/irq_cmd_engine.sv
module irq_cmd_engine
  import irq_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              bar_req,
  output logic              bar_ack,
  output logic              rb_done,
  output logic              rb_fault,
  output logic              rb_pend,
  output logic              rb_act,
  output logic              rb_en,
  output logic              rb_lvl,
  output logic [PRIO_W-1:0] rb_prio,
  output logic              rb_route,
  output logic [AFF_W-1:0]  rb_aff
);

  cmd_t   dec;
  cmd_t   s_cmd;
  logic   s_vld;
  logic   rdy_q;
  logic   acc;
  logic   sel_ok;
  entry_t sel_ent;
  entry_t st;

  irq_cmd_decode u_dec (
    .word (cmd_word),
    .cmd  (dec)
  );

  assign cmd_ready = rdy_q && !bar_req;
  assign acc       = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q   <= 1'b0;
      s_vld   <= 1'b0;
      s_cmd   <= '0;
      bar_ack <= 1'b0;
    end else begin
      rdy_q   <= 1'b1;
      s_vld   <= acc;
      if (acc) s_cmd <= dec;
      bar_ack <= bar_req && !s_vld && !acc;
    end
  end

  irq_state_table #(.NUM_IRQ(NUM_IRQ)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .upd_vld (s_vld),
    .upd     (s_cmd),
    .sel_ok  (sel_ok),
    .sel_ent (sel_ent)
  );

  irq_status_reg u_stat (
    .clk   (clk),
    .rst   (rst),
    .ld    (s_vld && (s_cmd.op == OP_RDBK)),
    .ok    (sel_ok),
    .ent   (sel_ent),
    .done  (rb_done),
    .fault (rb_fault),
    .st    (st)
  );

  assign rb_pend  = st.pend;
  assign rb_act   = st.act;
  assign rb_en    = st.en;
  assign rb_lvl   = st.lvl;
  assign rb_prio  = st.prio;
  assign rb_route = st.route;
  assign rb_aff   = st.aff;

endmodule

// File: rtl/irq_cmd_engine_chk.sv
module irq_cmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic bar_req,
  input logic bar_ack,
  input logic rb_done,
  input logic rb_fault,
  input logic rb_pend,
  input logic rb_act,
  input logic rb_en,
  input logic rb_lvl
);

  a_r11_no_accept_in_barrier: assert property (@(posedge clk) disable iff (rst)
    bar_req |-> !cmd_ready);

  a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    bar_ack |-> $past(bar_req));

  a_r11_ack_waits_inflight: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && cmd_ready, 2) |-> !bar_ack);

  a_r9_done_after_accept: assert property (@(posedge clk) disable iff (rst)
    rb_done |-> $past(cmd_valid && cmd_ready, 2));

  a_r9_fault_zero_fields: assert property (@(posedge clk) disable iff (rst)
    rb_fault |-> !(rb_pend || rb_act || rb_en || rb_lvl));

endmodule

bind irq_cmd_engine irq_cmd_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .bar_req   (bar_req),
  .bar_ack   (bar_ack),
  .rb_done   (rb_done),
  .rb_fault  (rb_fault),
  .rb_pend   (rb_pend),
  .rb_act    (rb_act),
  .rb_en     (rb_en),
  .rb_lvl    (rb_lvl)
);

// File: tb/tb_irq_cmd_engine.sv
module tb_irq_cmd_engine;

  localparam int NUM = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [63:0] cmd_word;
  logic        bar_req;
  logic        bar_ack;
  logic        rb_done, rb_fault, rb_pend, rb_act, rb_en, rb_lvl, rb_route;
  logic [4:0]  rb_prio;
  logic [15:0] rb_aff;

  int n_chk  = 0;
  int n_fail = 0;

  bit        m_en [NUM];
  bit        m_pend [NUM];
  bit        m_act [NUM];
  bit        m_lvl [NUM];
  bit        m_route [NUM];
  bit [4:0]  m_prio [NUM];
  bit [15:0] m_aff [NUM];
  logic [26:0] last_st;

  always #2 clk = ~clk;

  irq_cmd_engine #(.NUM_IRQ(NUM)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .bar_req(bar_req), .bar_ack(bar_ack),
    .rb_done(rb_done), .rb_fault(rb_fault), .rb_pend(rb_pend), .rb_act(rb_act),
    .rb_en(rb_en), .rb_lvl(rb_lvl), .rb_prio(rb_prio), .rb_route(rb_route),
    .rb_aff(rb_aff)
  );

  function automatic logic [26:0] stat_now();
    return {rb_fault, rb_pend, rb_act, rb_en, rb_lvl, rb_prio, rb_route, rb_aff};
  endfunction

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [2:0] typ,
                                     input logic [23:0] id, input logic [63:0] rnd);
    logic [63:0] w = rnd;
    w[63:60] = op;
    w[31:29] = typ;
    w[23:0]  = id;
    return w;
  endfunction

  function automatic logic [26:0] exp_rb(input logic [63:0] w);
    int id = int'(w[23:0]);
    if (w[31:29] != 3'd3 || w[23:0] >= 24'(NUM)) return {1'b1, 26'd0};
    return {1'b0, m_pend[id], m_act[id], m_en[id], m_lvl[id], m_prio[id],
            m_route[id], m_aff[id]};
  endfunction

  task automatic apply(input logic [63:0] w);
    int id = int'(w[23:0]);
    if (w[31:29] != 3'd3 || w[23:0] >= 24'(NUM)) return;
    case (w[63:60])
      4'd0: m_en[id] = 1'b1;
      4'd1: m_en[id] = 1'b0;
      4'd2: m_prio[id] = w[39:35];
      4'd3: begin m_aff[id] = w[47:32]; m_route[id] = w[28]; end
      4'd4: m_pend[id] = w[32];
      4'd5: m_act[id] = 1'b0;
      4'd7: m_lvl[id] = w[32];
      4'd8: if (m_en[id] && m_pend[id]) begin m_act[id] = 1'b1; m_pend[id] = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_rb(input logic [63:0] w, input string req);
    logic [26:0] e;
    send(w);
    @(negedge clk);
    e = exp_rb(w);
    chk(rb_done === 1'b1, {req, " R9 done strobe"}, 64'(rb_done), 64'd1);
    chk(stat_now() === e, req, 64'(stat_now()), 64'(e));
    last_st = e;
  endtask

  task automatic do_cmd(input logic [63:0] w, input string req);
    if (w[63:60] == 4'd6) begin
      do_rb(w, req);
    end else begin
      send(w);
      @(negedge clk);
      apply(w);
      chk(rb_done === 1'b0 && stat_now() === last_st, {req, " R9 status held"},
          64'(stat_now()), 64'(last_st));
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'd20240611));
    rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0; bar_req = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_lvl[i] = 0;
      m_route[i] = 0; m_prio[i] = '0; m_aff[i] = '0;
    end
    last_st = '0;
    repeat (4) @(negedge clk);
    chk(cmd_ready === 1'b0, "R12 ready low in reset", 64'(cmd_ready), 64'd0);
    chk(rb_done === 1'b0 && stat_now() === 27'd0, "R1 status after reset",
        64'(stat_now()), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R12 ready after reset", 64'(cmd_ready), 64'd1);

    // R1: whole table cleared
    for (int i = 0; i < NUM; i++) do_rb(mk(4'd6, 3'd3, 24'(i), 64'd0), "R1 reset entry");

    // R2: wrong type ignored, and readback of wrong type faults
    do_cmd(mk(4'd0, 3'd1, 24'd2, rnd64()), "R2 wrong type");
    do_rb(mk(4'd6, 3'd3, 24'd2, 64'd0), "R2 entry untouched");
    do_rb(mk(4'd6, 3'd5, 24'd2, 64'd0), "R2 wrong type readback fault");

    // R3: ID 16 aliases entry 0 in low bits
    do_cmd(mk(4'd0, 3'd3, 24'd16, rnd64()), "R3 out of range enable");
    do_cmd(mk(4'd2, 3'd3, 24'h800000, 64'h0000_00F8_0000_0000), "R3 huge id");
    do_rb(mk(4'd6, 3'd3, 24'd0, 64'd0), "R3 entry 0 untouched");
    do_rb(mk(4'd6, 3'd3, 24'd16, 64'd0), "R3 readback fault");

    // R4..R8 directed on entry 5
    do_cmd(mk(4'd0, 3'd3, 24'd5, 64'd0), "R4 enable");
    do_cmd(mk(4'd2, 3'd3, 24'd5, 64'h0000_00F8_0000_0000), "R5 priority 31");
    do_cmd(mk(4'd3, 3'd3, 24'd5, 64'h0000_BEEF_1000_0000), "R6 affinity");
    do_cmd(mk(4'd7, 3'd3, 24'd5, 64'h0000_0001_0000_0000), "R7 level mode");
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R4 R5 R6 R7 config");
    do_cmd(mk(4'd8, 3'd3, 24'd5, 64'd0), "R8 ack without pending");
    do_cmd(mk(4'd4, 3'd3, 24'd5, 64'h0000_0001_0000_0000), "R7 set pending");
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R7 pending set");
    do_cmd(mk(4'd8, 3'd3, 24'd5, 64'd0), "R8 ack");
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R8 active after ack");
    do_cmd(mk(4'd12, 3'd3, 24'd5, 64'hFFFF_FFFF_FFFF_FFFF), "R10 undefined op");
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R10 entry unchanged");
    do_cmd(mk(4'd5, 3'd3, 24'd5, 64'd0), "R8 eoi");
    do_cmd(mk(4'd4, 3'd3, 24'd5, 64'h0000_0001_0000_0000), "R7 set pending again");
    do_cmd(mk(4'd4, 3'd3, 24'd5, 64'd0), "R7 clear pending");
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R7 R8 after eoi and clear");

    // R11: barrier right after an accepted disable
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = mk(4'd1, 3'd3, 24'd5, 64'd0);
    @(negedge clk);
    cmd_valid = 1'b0; bar_req = 1'b1;
    apply(mk(4'd1, 3'd3, 24'd5, 64'd0));
    @(negedge clk);
    chk(bar_ack === 1'b0, "R11 ack waits for disable", 64'(bar_ack), 64'd0);
    chk(cmd_ready === 1'b0, "R11 ready low in barrier", 64'(cmd_ready), 64'd0);
    cmd_valid = 1'b1; cmd_word = mk(4'd0, 3'd3, 24'd5, 64'd0);
    @(negedge clk);
    chk(bar_ack === 1'b1, "R11 ack after drain", 64'(bar_ack), 64'd1);
    cmd_valid = 1'b0; bar_req = 1'b0;
    @(negedge clk);
    chk(bar_ack === 1'b0, "R11 ack drops", 64'(bar_ack), 64'd0);
    do_rb(mk(4'd6, 3'd3, 24'd5, 64'd0), "R11 disabled, held enable refused");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] typ;
      typ = ($urandom % 5 == 0) ? 3'($urandom) : 3'd3;
      w = mk(4'($urandom % 16), typ, 24'($urandom % 20), rnd64());
      do_cmd(w, "R2 R3 R4 R5 R6 R7 R8 R10 random");
      do_rb(mk(4'd6, 3'd3, 24'($urandom % 20), 64'd0), "R9 random readback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule